// File: doc/BRIEF.md
# Ethernet receive address filter

This block watches the first twelve bytes of every received frame, treats bytes 0 to 5 as the destination MAC and bytes 6 to 11 as the source MAC, and judges whether the frame should be kept. It keeps a primary unicast address and a set of extra destination entries, plus a set of source entries. Every extra entry has its own enable bit and a mask with one bit per byte. It also keeps a 256-bin hash table, indexed from a CRC of the destination address, and a few mode bits that widen or narrow acceptance.

The decision appears as a one-cycle pulse together with a 16-bit status word. The word reports which perfect entries hit, whether the hash table hit, and how the destination was classified. Software loads the tables and the mode through a simple word-wide write port. In promiscuous mode every frame is kept, and the status still carries the full filter outcome, so a monitor can log it.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: The byte flagged `in_sof` is byte 0. The next accepted bytes fill positions 1 to 11, and cycles with `in_valid` low are skipped. In the cycle after byte 11 is presented, `dec_valid` is high for exactly one cycle. Bytes after byte 11 do not produce a further decision until the next `in_sof`.
- R2: Word writes are decoded as follows. Destination entry i (0..31) sits at 0x40+2i. Its even word holds bytes 0 to 3, with byte 0 in bits 7:0. Its odd word holds bytes 4 and 5 in bits 15:0, the byte mask in bits 21:16 (bit k set means byte k is ignored), and the enable in bit 31. Entry 0 is the primary address: it is always enabled and never masked. A destination hit needs an enabled entry whose unmasked bytes all equal the frame's destination.
- R3: Status bit 0 reports a destination hit. Bits 5:1 give the lowest-numbered entry that hit, and are zero when no entry hit.
- R4: Source entry j (0..30) sits at 0x80+2j and uses the same layout as a destination entry. Status bit 6 is a source hit and bits 11:7 give the lowest hitting source index. When the source-gate mode bit is set, a frame with no source hit is dropped.
- R5: The hash bin is the top byte, bits 31:24, of the inverted CRC-32 of the six destination bytes. The CRC is computed LSB first with the reflected polynomial 0xEDB88320 and a start value of all ones. The table word at 0x08+k holds bins 32k to 32k+31. Status bit 12 is set when the bin is set and the hash is enabled for that address class: mode bit 4 for group addresses, mode bit 3 for individual addresses. A hash hit passes the frame.
- R6: With mode bit 1 set, any destination with bit 0 of byte 0 set (group) is passed. Status bit 14 reports the group bit.
- R7: The all-ones destination is reported in status bit 13. It passes unless mode bit 2 is set, and that disable also overrides mode bit 1.
- R8: Mode bit 0 (promiscuous) forces the pass bit, status bit 15 and `dec_pass`, to one. All other status fields are unchanged.
- R9: If `in_eof` arrives on a byte before byte 11, no decision is made. Bytes that arrive without a preceding `in_sof` are ignored. A new `in_sof` in the middle of a header restarts the count.
- R10: The mode register is at 0x00, bits 5:0. A table or mode write that lands in the same cycle as byte 11 does not affect that frame's decision, and it does apply to the next frame.
- R11: After reset, `dec_valid`, `dec_pass` and `dec_status` are zero. After reset, all tables and the mode are zero, and the primary address is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte is present |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | This byte is byte 0 of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_pass | output | 1 | Frame accepted |
| dec_status | output | 16 | Filter status word |

## Verification
A register write and the arrival of header byte 11 can land on the same clock edge. The decision logic reads the tables while the write port updates them. The bench issues a write of the mode or of an entry in exactly the cycle it presents byte 11. It expects that frame to be judged under the old contents, and the following identical frame to be judged under the new ones. It also overlaps a fresh start marker with an unfinished header, and expects a single decision counted from the restart.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;
  localparam int MAC_BYTES = 6;
  localparam int HDR_BYTES = 12;
  localparam int MAC_W     = 48;
  localparam int IDX_W     = 5;
  localparam int STAT_W    = 16;
  localparam int HASH_BINS = 256;
  localparam int HASH_WORDS = HASH_BINS / 32;
  localparam int CFG_AW    = 8;
  localparam int CFG_DW    = 32;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // mode bit 0 is promisc
  typedef struct packed {
    logic sa_gate;
    logic hash_mc;
    logic hash_uc;
    logic bcast_off;
    logic all_mcast;
    logic promisc;
  } mode_t;

  localparam int ST_DA_HIT = 0;
  localparam int ST_DA_IDX = 1;
  localparam int ST_SA_HIT = 6;
  localparam int ST_SA_IDX = 7;
  localparam int ST_HASH   = 12;
  localparam int ST_BCAST  = 13;
  localparam int ST_GROUP  = 14;
  localparam int ST_PASS   = 15;

  // one byte through the reflected CRC register, LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] hash_bin(input logic [31:0] crc_reg);
    logic [31:0] fin;
    fin = ~crc_reg;
    return fin[31:24];
  endfunction
endpackage

// File: rtl/eth_af_cfg_regs.sv
module eth_af_cfg_regs
  import eth_af_pkg::*;
#(
  parameter int NDA = 32,
  parameter int NSA = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [CFG_DW-1:0]         cfg_wdata,
  output mode_t                     mode,
  output logic [HASH_BINS-1:0]      hash_tbl,
  output logic [NDA-1:0][MAC_W-1:0] da_addr,
  output logic [NDA-1:0][MAC_BYTES-1:0] da_mask,
  output logic [NDA-1:0]            da_en,
  output logic [NSA-1:0][MAC_W-1:0] sa_addr,
  output logic [NSA-1:0][MAC_BYTES-1:0] sa_mask,
  output logic [NSA-1:0]            sa_en
);
  // address decode regions
  wire mode_sel = cfg_we && (cfg_addr == 8'h00);
  wire hash_rgn = cfg_we && (cfg_addr[7:3] == 5'b00001);
  wire da_rgn   = cfg_we && (cfg_addr[7:6] == 2'b01);
  wire sa_rgn   = cfg_we && (cfg_addr[7:6] == 2'b10);

  initial begin
    assert_table_size_R2: assert (NDA >= 1 && NDA <= 32 && NSA >= 1 && NSA <= 32);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mode <= '0;
    else if (mode_sel) mode <= mode_t'(cfg_wdata[5:0]);
  end

  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (hash_rgn && cfg_addr[2:0] == 3'(k)) word_q <= cfg_wdata;
    end
    assign hash_tbl[32*k +: 32] = word_q;
  end

  for (genvar i = 0; i < NDA; i++) begin : g_da
    wire sel_lo = da_rgn && (cfg_addr[5:1] == 5'(i)) && !cfg_addr[0];
    wire sel_hi = da_rgn && (cfg_addr[5:1] == 5'(i)) &&  cfg_addr[0];
    logic [MAC_W-1:0] a_q;
    always_ff @(posedge clk) begin
      if (!rst_n) a_q <= '0;
      else begin
        if (sel_lo) a_q[31:0]  <= cfg_wdata;
        if (sel_hi) a_q[47:32] <= cfg_wdata[15:0];
      end
    end
    assign da_addr[i] = a_q;
    if (i == 0) begin : g_primary
      assign da_mask[i] = '0;
      assign da_en[i]   = 1'b1;
    end else begin : g_extra
      logic [MAC_BYTES-1:0] m_q;
      logic                 e_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          m_q <= '0;
          e_q <= 1'b0;
        end else if (sel_hi) begin
          m_q <= cfg_wdata[21:16];
          e_q <= cfg_wdata[31];
        end
      end
      assign da_mask[i] = m_q;
      assign da_en[i]   = e_q;
    end
  end

  for (genvar j = 0; j < NSA; j++) begin : g_sa
    wire sel_lo = sa_rgn && (cfg_addr[5:1] == 5'(j)) && !cfg_addr[0];
    wire sel_hi = sa_rgn && (cfg_addr[5:1] == 5'(j)) &&  cfg_addr[0];
    logic [MAC_W-1:0]     a_q;
    logic [MAC_BYTES-1:0] m_q;
    logic                 e_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
        m_q <= '0;
        e_q <= 1'b0;
      end else begin
        if (sel_lo) a_q[31:0] <= cfg_wdata;
        if (sel_hi) begin
          a_q[47:32] <= cfg_wdata[15:0];
          m_q        <= cfg_wdata[21:16];
          e_q        <= cfg_wdata[31];
        end
      end
    end
    assign sa_addr[j] = a_q;
    assign sa_mask[j] = m_q;
    assign sa_en[j]   = e_q;
  end
endmodule

// File: rtl/eth_af_hdr_capture.sv
module eth_af_hdr_capture
  import eth_af_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic [MAC_W-1:0] da,
  output logic [MAC_W-1:0] sa_live,
  output logic [7:0]       hash_idx,
  output logic             byte_take,
  output logic             hdr_done
);
  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] HDR_FULL = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] DA_END   = CNT_W'(MAC_BYTES);

  // cnt: 0 idle, 1..11 next byte position, 12 header complete
  logic [CNT_W-1:0]                cnt;
  logic [HDR_BYTES-2:0][7:0]       hb;
  logic [31:0]                     crc;
  logic [CNT_W-1:0]                pos;

  assign pos       = in_sof ? '0 : cnt;
  assign byte_take = in_valid && (in_sof || (cnt != '0 && cnt < HDR_FULL));
  assign hdr_done  = byte_take && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (byte_take) begin
      if (pos == LAST_POS) cnt <= HDR_FULL;
      else if (in_eof)     cnt <= '0;
      else                 cnt <= pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb  <= '0;
      crc <= '1;
    end else if (byte_take) begin
      if (pos < LAST_POS) hb[pos] <= in_byte;
      if (pos == '0)          crc <= crc_step(32'hFFFF_FFFF, in_byte);
      else if (pos < DA_END)  crc <= crc_step(crc, in_byte);
    end
  end

  assign da       = hb[MAC_BYTES-1:0];
  assign sa_live  = {in_byte, hb[HDR_BYTES-2:MAC_BYTES]};
  assign hash_idx = hash_bin(crc);

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= HDR_FULL);
  assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> !hdr_done);
  assert_runt_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && in_eof && pos < LAST_POS) |=> !hdr_done);
endmodule

// File: rtl/eth_af_match_bank.sv
module eth_af_match_bank
  import eth_af_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [MAC_W-1:0]             key,
  input  logic [N-1:0][MAC_W-1:0]      ent_addr,
  input  logic [N-1:0][MAC_BYTES-1:0]  ent_mask,
  input  logic [N-1:0]                 ent_en,
  output logic [N-1:0]                 hit_vec,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [MAC_BYTES-1:0] byte_ok;
    for (genvar b = 0; b < MAC_BYTES; b++) begin : g_byte
      assign byte_ok[b] = ent_mask[i][b] ||
                          (key[8*b +: 8] == ent_addr[i][8*b +: 8]);
    end
    assign hit_vec[i] = ent_en[i] && (&byte_ok);
  end

  // lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
  assign hit = |hit_vec;

  always_comb begin
    if (hit) begin
      assert_idx_hits_R3: assert (hit_vec[hit_idx]);
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_af_pkg::*;
#(
  parameter int NDA = 32,
  parameter int NSA = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_byte,
  input  logic         in_sof,
  input  logic         in_eof,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_addr,
  input  logic [31:0]  cfg_wdata,
  output logic         dec_valid,
  output logic         dec_pass,
  output logic [15:0]  dec_status
);
  mode_t                         mode;
  logic [HASH_BINS-1:0]          hash_tbl;
  logic [NDA-1:0][MAC_W-1:0]     da_addr;
  logic [NDA-1:0][MAC_BYTES-1:0] da_mask;
  logic [NDA-1:0]                da_en;
  logic [NSA-1:0][MAC_W-1:0]     sa_addr;
  logic [NSA-1:0][MAC_BYTES-1:0] sa_mask;
  logic [NSA-1:0]                sa_en;

  logic [MAC_W-1:0] da, sa_live;
  logic [7:0]       hash_idx;
  logic             byte_take, hdr_done;

  logic [NDA-1:0]   da_vec;
  logic [NSA-1:0]   sa_vec;
  logic             da_hit, sa_hit;
  logic [IDX_W-1:0] da_idx, sa_idx;

  eth_af_cfg_regs #(.NDA(NDA), .NSA(NSA)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode(mode), .hash_tbl(hash_tbl),
    .da_addr(da_addr), .da_mask(da_mask), .da_en(da_en),
    .sa_addr(sa_addr), .sa_mask(sa_mask), .sa_en(sa_en)
  );

  eth_af_hdr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_sof(in_sof), .in_eof(in_eof), .da(da), .sa_live(sa_live),
    .hash_idx(hash_idx), .byte_take(byte_take), .hdr_done(hdr_done)
  );

  eth_af_match_bank #(.N(NDA)) u_da_bank (
    .key(da), .ent_addr(da_addr), .ent_mask(da_mask), .ent_en(da_en),
    .hit_vec(da_vec), .hit(da_hit), .hit_idx(da_idx)
  );

  eth_af_match_bank #(.N(NSA)) u_sa_bank (
    .key(sa_live), .ent_addr(sa_addr), .ent_mask(sa_mask), .ent_en(sa_en),
    .hit_vec(sa_vec), .hit(sa_hit), .hit_idx(sa_idx)
  );

  // classification and decision
  wire da_group  = da[0];
  wire da_bcast  = &da;
  wire bin_set   = hash_tbl[hash_idx];
  wire hash_hit  = bin_set && (da_group ? mode.hash_mc : mode.hash_uc);
  wire mc_open   = da_group && mode.all_mcast;
  wire da_accept = da_bcast ? !mode.bcast_off : (da_hit || hash_hit || mc_open);
  wire sa_accept = !mode.sa_gate || sa_hit;
  wire pass_now  = mode.promisc || (da_accept && sa_accept);

  logic [STAT_W-1:0] status_now;
  always_comb begin
    status_now = '0;
    status_now[ST_DA_HIT]                = da_hit;
    status_now[ST_DA_IDX +: IDX_W]       = da_idx;
    status_now[ST_SA_HIT]                = sa_hit;
    status_now[ST_SA_IDX +: IDX_W]       = sa_idx;
    status_now[ST_HASH]                  = hash_hit;
    status_now[ST_BCAST]                 = da_bcast;
    status_now[ST_GROUP]                 = da_group;
    status_now[ST_PASS]                  = pass_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_pass   <= 1'b0;
      dec_status <= '0;
    end else begin
      dec_valid <= hdr_done;
      if (hdr_done) begin
        dec_pass   <= pass_now;
        dec_status <= status_now;
      end
    end
  end

  assert_dec_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_idx_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_status[ST_DA_HIT]) |-> (dec_status[ST_DA_IDX +: IDX_W] == '0));
  assert_sa_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(mode.sa_gate) && !$past(mode.promisc) && !dec_status[ST_SA_HIT])
      |-> !dec_pass);
  assert_bcast_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_status[ST_BCAST] && !$past(mode.bcast_off) && !$past(mode.sa_gate))
      |-> dec_pass);
  assert_bcast_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_status[ST_BCAST] && $past(mode.bcast_off) && !$past(mode.promisc))
      |-> !dec_pass);
  assert_promisc_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(mode.promisc)) |-> dec_pass);
endmodule

// File: tb/sim_eth_rx_addr_filter.sv
module sim_eth_rx_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_byte = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic dec_valid, dec_pass;
  logic [15:0] dec_status;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  eth_rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_pass(dec_pass),
    .dec_status(dec_status)
  );

  localparam logic [47:0] PRIM = 48'h010000000002;
  localparam logic [47:0] E3   = 48'h554433221102;
  localparam logic [47:0] E3V  = 48'h014433221102;
  localparam logic [47:0] E7   = 48'h664433221102;
  localparam logic [47:0] NM   = 48'h554533221102;
  localparam logic [47:0] E9   = 48'haaaaaaaaaa02;
  localparam logic [47:0] UCH  = 48'h777777777702;
  localparam logic [47:0] MC   = 48'hfb00005e0001;
  localparam logic [47:0] OMC  = 48'h3322115e0001;
  localparam logic [47:0] OUC  = 48'h999999999902;
  localparam logic [47:0] BC   = 48'hffffffffffff;
  localparam logic [47:0] SAO  = 48'h111111111100;
  localparam logic [47:0] SA2  = 48'h100000c25000;
  localparam logic [47:0] SA2V = 48'hcdab00c25000;

  typedef struct packed {
    logic [47:0] da;
    logic [47:0] sa;
    logic [5:0]  mode;
    logic        pass;
    logic        dh;
    logic [4:0]  di;
    logic        sh;
    logic [4:0]  si;
  } vec_t;

  // mode: b0 promisc, b1 all-mcast, b2 bcast off, b3 hash uc, b4 hash mc, b5 sa gate
  localparam vec_t VEC [20] = '{
    '{PRIM, SAO,  6'h00, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0},  // R2 primary
    '{E3V,  SAO,  6'h00, 1'b1, 1'b1, 5'd3, 1'b0, 5'd0},  // R2 masked byte
    '{E7,   SAO,  6'h00, 1'b1, 1'b1, 5'd3, 1'b0, 5'd0},  // R3 lowest index
    '{NM,   SAO,  6'h00, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R2 unmasked mismatch
    '{E9,   SAO,  6'h00, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R2 disabled entry
    '{UCH,  SAO,  6'h00, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R5 hash off
    '{UCH,  SAO,  6'h08, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0},  // R5 uc hash
    '{UCH,  SAO,  6'h10, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R5 wrong class
    '{MC,   SAO,  6'h10, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0},  // R5 mc hash
    '{MC,   SAO,  6'h08, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R5 wrong class
    '{OMC,  SAO,  6'h02, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0},  // R6
    '{OMC,  SAO,  6'h00, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R6
    '{BC,   SAO,  6'h00, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0},  // R7
    '{BC,   SAO,  6'h04, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R7
    '{BC,   SAO,  6'h06, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0},  // R7 overrides R6
    '{PRIM, SA2V, 6'h20, 1'b1, 1'b1, 5'd0, 1'b1, 5'd2},  // R4 masked sa
    '{PRIM, SAO,  6'h20, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0},  // R4 gate drop
    '{OUC,  SAO,  6'h01, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0},  // R8
    '{BC,   SAO,  6'h05, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0},  // R8
    '{PRIM, SAO,  6'h21, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0}   // R8
  };

  logic [255:0] shadow = '0;

  // hash bin restated over the whole 48-bit address, bit by bit
  function automatic logic [7:0] bin_of(input logic [47:0] mac);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[0] ^ mac[k];
      c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    c = ~c;
    return c[31:24];
  endfunction

  function automatic logic [15:0] exp_status(input vec_t v, input logic [255:0] tbl);
    logic grp, bc, hh;
    grp = v.da[0];
    bc  = (v.da == 48'hffffffffffff);
    hh  = tbl[bin_of(v.da)] && (grp ? v.mode[4] : v.mode[3]);
    return {v.pass, grp, bc, hh, v.si, v.sh, v.di, v.dh};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_entry(input logic [7:0] base, input int i, input logic [47:0] mac,
                          input logic [5:0] msk, input logic en);
    wr(base + 8'(2*i), mac[31:0]);
    wr(base + 8'(2*i + 1), {en, 9'b0, msk, mac[47:32]});
  endtask

  task automatic put(input logic [7:0] b, input logic s, input logic e);
    in_valid = 1'b1; in_byte = b; in_sof = s; in_eof = e;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // sends 12 header bytes; optional idle gaps; optional write landing with byte 11
  task automatic send(input logic [47:0] da, input logic [47:0] sa, input logic gaps,
                      input logic wr_last, input logic [7:0] wa, input logic [31:0] wd);
    logic [95:0] h;
    h = {sa, da};
    for (int k = 0; k < 12; k++) begin
      if (k == 11 && wr_last) begin
        cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
      end
      put(h[8*k +: 8], k == 0, k == 11);
      cfg_we = 1'b0;
      if (gaps && k < 11) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic seen;
    logic [15:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset outputs
    check("R11 valid", 32'(dec_valid), 0);
    check("R11 pass", 32'(dec_pass), 0);
    check("R11 status", 32'(dec_status), 0);
    // R11 tables zero: all-zero primary hits, others drop
    send(48'h0, SAO, 1'b0, 1'b0, 8'h0, 0);
    check("R11 zero primary", {15'b0, dec_valid, dec_status}, {15'b0, 1'b1, 16'h8001});
    @(negedge clk);
    send(OUC, SAO, 1'b0, 1'b0, 8'h0, 0);
    check("R11 empty tables", {15'b0, dec_valid, dec_status}, {15'b0, 1'b1, 16'h0000});
    @(negedge clk);

    // program tables
    wr_entry(8'h40, 0, PRIM, 6'h00, 1'b1);
    wr_entry(8'h40, 3, E3, 6'b100000, 1'b1);
    wr_entry(8'h40, 7, E7, 6'b000000, 1'b1);
    wr_entry(8'h40, 9, E9, 6'b000000, 1'b0);
    wr_entry(8'h80, 2, SA2, 6'b110000, 1'b1);
    shadow[bin_of(UCH)] = 1'b1;
    shadow[bin_of(MC)]  = 1'b1;
    for (int w = 0; w < 8; w++) wr(8'h08 + 8'(w), shadow[32*w +: 32]);

    // vector table
    for (int n = 0; n < 20; n++) begin
      wr(8'h00, {26'b0, VEC[n].mode});
      send(VEC[n].da, VEC[n].sa, n[0], 1'b0, 8'h0, 0);
      check($sformatf("R1 vec%0d valid", n), 32'(dec_valid), 1);
      check($sformatf("R2-table vec%0d pass", n), 32'(dec_pass), 32'(VEC[n].pass));
      check($sformatf("R3 R4 R5 R6 R7 R8 vec%0d status", n), 32'(dec_status),
            32'(exp_status(VEC[n], shadow)));
      @(negedge clk);
      check($sformatf("R1 vec%0d pulse ends", n), 32'(dec_valid), 0);
    end
    wr(8'h00, 0);

    // R9 runt: eof on byte 6
    seen = 1'b0;
    for (int k = 0; k < 7; k++) put(PRIM[7:0], k == 0, k == 6);
    for (int k = 0; k < 8; k++) begin
      if (dec_valid) seen = 1'b1;
      put(8'h02, 1'b0, 1'b0);
    end
    check("R9 runt and headless bytes", 32'(seen), 0);

    // R9 restart mid header: 5 bytes of OUC then a fresh PRIM frame
    for (int k = 0; k < 5; k++) put(OUC[8*k +: 8], k == 0, 1'b0);
    seen = 1'b0;
    begin
      logic [95:0] h;
      h = {SAO, PRIM};
      for (int k = 0; k < 11; k++) begin
        put(h[8*k +: 8], k == 0, 1'b0);
        if (dec_valid) seen = 1'b1;
      end
      put(h[95:88], 1'b0, 1'b1);
    end
    check("R9 no early decision", 32'(seen), 0);
    check("R9 restart decision", {15'b0, dec_valid, dec_status}, {15'b0, 1'b1, 16'h8001});
    @(negedge clk);

    // R1 bytes after byte 11 give no second decision
    seen = 1'b0;
    for (int k = 0; k < 14; k++) begin
      put(8'h55, 1'b0, k == 13);
      if (dec_valid) seen = 1'b1;
    end
    check("R1 trailing bytes", 32'(seen), 0);

    // R10 mode write on byte 11 edge
    send(OUC, SAO, 1'b0, 1'b1, 8'h00, 32'h1);
    check("R10 old mode used", 32'(dec_pass), 0);
    @(negedge clk);
    send(OUC, SAO, 1'b0, 1'b0, 8'h0, 0);
    check("R10 new mode next frame", 32'(dec_pass), 1);
    @(negedge clk);
    wr(8'h00, 0);

    // R10 entry write on byte 11 edge (entry 4 odd word enables OUC after low word)
    wr(8'h48, OUC[31:0]);
    send(OUC, SAO, 1'b0, 1'b1, 8'h49, {1'b1, 9'b0, 6'b0, OUC[47:32]});
    st = dec_status;
    check("R10 entry not yet live", 32'(st), 0);
    @(negedge clk);
    send(OUC, SAO, 1'b1, 1'b0, 8'h0, 0);
    check("R10 entry live next frame", 32'(dec_status), 32'h8009);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule